// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Sequencer

This block sits at the front of a small 32-bit load-store core. It keeps the instruction pointer and reads the program one halfword at a time from an asynchronous ROM. For each issue it hands the core one whole instruction. Most instructions take one halfword. The immediate-move forms take two. The most significant bit of the first halfword tells the two apart. A 32-bit instruction takes two cycles to issue: the first cycle reads its opening halfword and issues nothing, and the second cycle issues both halves together.

The core decodes each issued instruction in the cycle it appears. It answers in that same cycle with a jump request, which carries a register-sourced target, or with an interrupt request, which carries a 3-bit number. A taken jump always executes exactly one delay slot, the next sequential instruction, and then continues at the target. Only the low address bits of the target are used. Interrupt number 1 means the program has finished: the sequencer stops issuing and stays halted until reset. A 32-bit instruction that starts on an odd halfword address is flagged on an error output.

Top module: `mixlen_fetch_seq`

## Requirements
- R1: After reset the ROM address is 0, halt is low and align_err is low.
- R2: When the halfword at the instruction pointer has bit 15 equal to 0, issue_valid is high in that same cycle. issue_instr is {halfword, 16'h0000}, and the next read is at pointer+1.
- R3: When that halfword has bit 15 equal to 1, issue_valid is low in that cycle. The next cycle reads pointer+1 and issues {first halfword, second halfword}, and the read after that is at pointer+2.
- R4: A jump_req in a cycle with issue_valid high is followed by exactly one delay-slot instruction taken from the sequential address. The instruction after the slot is read at the target.
- R5: When the delay slot is a 32-bit instruction, the redirect happens only after both of its halves have issued.
- R6: Only the low AW bits of jump_target are used as the target address.
- R7: A jump_req made while the delay slot is issuing is ignored. The earlier target still wins.
- R8: An int_req with int_num equal to 1, in a cycle with issue_valid high, sets halt from the next cycle on. While halt is high, issue_valid stays low, requests are ignored, and halt stays high until reset.
- R9: An int_req with any other int_num has no effect on halt or on sequencing.
- R10: align_err is high exactly in the cycle that reads the first halfword of a 32-bit instruction at an odd address. That instruction still issues normally in the next cycle.
- R11: jump_req and int_req are ignored in a cycle where issue_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | AW | Halfword address to the ROM |
| rom_rdata | input | 16 | Halfword read from rom_addr in the same cycle |
| issue_valid | output | 1 | A complete instruction is on issue_instr |
| issue_instr | output | 32 | Issued instruction, first halfword in bits 31:16 |
| jump_req | input | 1 | Core requests a taken jump for the issued instruction |
| jump_target | input | TW | Jump target register value |
| int_req | input | 1 | Core executes an interrupt instruction |
| int_num | input | 3 | Interrupt number |
| halt | output | 1 | Program finished, core stopped |
| align_err | output | 1 | 32-bit instruction starts on an odd halfword |

## Verification
The bench uses the defaults AW=16 and TW=32, so every jump target carries high bits that must be dropped, and the truncation variant of the target path is the one built. With a 16-bit address, targets such as 0xFFFF_0020 land inside the bench's 64-entry ROM only if exactly the low bits are kept. Directed programs cover these cases:
- short and long instructions back to back;
- jumps whose slot is short, long, or itself a jump;
- finish and non-finish interrupts;
- a 32-bit instruction placed at an odd address.

// File: rtl/mixlen_seq_pkg.sv
package mixlen_seq_pkg;
   localparam int HALF_W = 16;
   localparam int INT_W  = 3;
   typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_t;
endpackage

// File: rtl/mixlen_seq_asm.sv
module mixlen_seq_asm
   import mixlen_seq_pkg::*;
#(
   parameter int HW = HALF_W
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halted,
   input  logic [HW-1:0]   rdata,
   output logic            second_ph,
   output logic            first_long,
   output logic            done,
   output logic [2*HW-1:0] instr
);
   localparam int LEN_BIT = HW - 1;

   phase_t        phase_q;
   logic [HW-1:0] hold_q;

   always_comb begin
      second_ph  = (phase_q == PH_SECOND);
      first_long = !halted && !second_ph && rdata[LEN_BIT];
      done       = !halted && (second_ph || !rdata[LEN_BIT]);
      instr      = second_ph ? {hold_q, rdata} : {rdata, {HW{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_FIRST;
         hold_q  <= '0;
      end else if (first_long) begin
         phase_q <= PH_SECOND;
         hold_q  <= rdata;
      end else if (second_ph) begin
         phase_q <= PH_FIRST;
      end
   end

   // R3: the second half is always read right after a long first half
   p_second_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      first_long |=> (second_ph && done));
endmodule

// File: rtl/mixlen_seq_ip.sv
module mixlen_seq_ip #(
   parameter int AW = 16,
   parameter int TW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic          second_ph,
   input  logic          jump_req,
   input  logic [TW-1:0] jump_tgt,
   output logic [AW-1:0] rom_addr
);
   logic [AW-1:0] ip_q;
   logic [AW-1:0] tgt_q;
   logic          pend_q;
   logic [AW-1:0] tgt_trim;
   logic [AW-1:0] seq_next;

   generate
      if (TW > AW) begin : g_trim
         logic unused_tgt_hi;
         assign unused_tgt_hi = ^jump_tgt[TW-1:AW];
         assign tgt_trim = jump_tgt[AW-1:0];
      end else if (TW == AW) begin : g_same
         assign tgt_trim = jump_tgt;
      end else begin : g_extend
         assign tgt_trim = {{(AW-TW){1'b0}}, jump_tgt};
      end
   endgenerate

   always_comb begin
      rom_addr = ip_q + AW'(second_ph);
      seq_next = ip_q + (second_ph ? AW'(2) : AW'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q   <= '0;
         tgt_q  <= '0;
         pend_q <= 1'b0;
      end else if (done) begin
         if (pend_q) begin
            ip_q   <= tgt_q;
            pend_q <= 1'b0;
         end else begin
            ip_q <= seq_next;
            if (jump_req) begin
               pend_q <= 1'b1;
               tgt_q  <= tgt_trim;
            end
         end
      end
   end

   // R4: the read after a jump issue is the next sequential halfword
   p_slot_sequential_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && jump_req && !pend_q) |=> (rom_addr == $past(rom_addr) + AW'(1)));
endmodule

// File: rtl/mixlen_seq_halt.sv
module mixlen_seq_halt
   import mixlen_seq_pkg::*;
#(
   parameter int FIN_CODE = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             int_req,
   input  logic [INT_W-1:0] int_num,
   output logic             halted
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         halted <= 1'b0;
      else if (done && int_req && (int_num == INT_W'(FIN_CODE)))
         halted <= 1'b1;
   end

   // R8: once stopped, stays stopped
   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
endmodule

// File: rtl/mixlen_fetch_seq.sv
module mixlen_fetch_seq
   import mixlen_seq_pkg::*;
#(
   parameter int AW       = 16,
   parameter int TW       = 32,
   parameter int FIN_CODE = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   output logic [AW-1:0]    rom_addr,
   input  logic [15:0]      rom_rdata,
   output logic             issue_valid,
   output logic [31:0]      issue_instr,
   input  logic             jump_req,
   input  logic [TW-1:0]    jump_target,
   input  logic             int_req,
   input  logic [2:0]       int_num,
   output logic             halt,
   output logic             align_err
);
   generate
      if (AW < 2 || AW > 16) begin : g_bad_aw
         $error("AW must be within 2..16");
      end
      if (TW < 1) begin : g_bad_tw
         $error("TW must be at least 1");
      end
      if (FIN_CODE < 0 || FIN_CODE >= (1 << INT_W)) begin : g_bad_fin
         $error("FIN_CODE must fit the interrupt number field");
      end
   endgenerate

   logic second_ph;
   logic first_long;
   logic done;

   mixlen_seq_asm #(.HW(HALF_W)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halted     (halt),
      .rdata      (rom_rdata),
      .second_ph  (second_ph),
      .first_long (first_long),
      .done       (done),
      .instr      (issue_instr)
   );

   mixlen_seq_ip #(.AW(AW), .TW(TW)) u_ip (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .second_ph (second_ph),
      .jump_req  (jump_req),
      .jump_tgt  (jump_target),
      .rom_addr  (rom_addr)
   );

   mixlen_seq_halt #(.FIN_CODE(FIN_CODE)) u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done),
      .int_req (int_req),
      .int_num (int_num),
      .halted  (halt)
   );

   assign issue_valid = done;
   assign align_err   = first_long && rom_addr[0];

   // R8: nothing issues while stopped
   p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !issue_valid);
   // R3: an empty issue cycle that is not a halt is followed by an issue
   p_gap_then_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_valid && !halt) |=> issue_valid);
   // R10: a flagged instruction still completes in the next cycle
   p_err_completes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |=> issue_valid);
endmodule

// File: tb/sim_mixlen_fetch_seq.sv
module sim_mixlen_fetch_seq;
   localparam int AW = 16;
   localparam int TW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] rom_addr;
   logic [15:0]   rom_rdata;
   logic          issue_valid;
   logic [31:0]   issue_instr;
   logic          jump_req;
   logic [TW-1:0] jump_target;
   logic          int_req;
   logic [2:0]    int_num;
   logic          halt;
   logic          align_err;

   logic [15:0] mem [0:63];
   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   assign rom_rdata = mem[rom_addr[5:0]];

   mixlen_fetch_seq #(.AW(AW), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .issue_valid(issue_valid), .issue_instr(issue_instr),
      .jump_req(jump_req), .jump_target(jump_target),
      .int_req(int_req), .int_num(int_num), .halt(halt), .align_err(align_err)
   );

   task automatic clear_rom();
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; jump_req = 1'b0; jump_target = '0; int_req = 1'b0; int_num = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive the inputs for one cycle, check the outputs, then move to the next negedge.
   // ea = 16'hFFFF means the address is not checked.
   task automatic cyc(input string tag, input bit jr, input logic [31:0] jt,
                      input bit ir, input logic [2:0] inum,
                      input bit ev, input logic [31:0] ei, input logic [15:0] ea,
                      input bit eh, input bit ee);
      jump_req = jr; jump_target = jt; int_req = ir; int_num = inum;
      #1;
      checks++;
      if (issue_valid !== ev || (ev && issue_instr !== ei) ||
          (ea != 16'hFFFF && rom_addr !== ea) || halt !== eh || align_err !== ee) begin
         failures++;
         $display("FAIL %s: got valid=%0b instr=%h addr=%h halt=%0b err=%0b, expected valid=%0b instr=%h addr=%h halt=%0b err=%0b",
                  tag, issue_valid, issue_instr, rom_addr, halt, align_err, ev, ei, ea, eh, ee);
      end
      @(negedge clk);
      jump_req = 1'b0; int_req = 1'b0;
   endtask

   task automatic t_sequential();
      clear_rom();
      mem[0] = 16'h1234; mem[1] = 16'h2001; mem[2] = 16'h8abc; mem[3] = 16'h5555;
      mem[4] = 16'h0042; mem[5] = 16'h0055;
      do_reset();
      cyc("R1 reset state", 0, 0, 0, 0, 1, 32'h1234_0000, 16'h0000, 0, 0);
      cyc("R2 short issue", 0, 0, 0, 0, 1, 32'h2001_0000, 16'h0001, 0, 0);
      // R11: requests in the long instruction's empty cycle must be ignored
      cyc("R3 long first half R11", 1, 32'h30, 1, 3'd1, 0, 32'h0, 16'h0002, 0, 0);
      cyc("R3 long second half", 0, 0, 0, 0, 1, 32'h8abc_5555, 16'h0003, 0, 0);
      cyc("R3 after long", 0, 0, 0, 0, 1, 32'h0042_0000, 16'h0004, 0, 0);
      cyc("R11 no redirect", 0, 0, 0, 0, 1, 32'h0055_0000, 16'h0005, 0, 0);
   endtask

   task automatic t_jump_short_slot();
      clear_rom();
      mem[0] = 16'h0100; mem[1] = 16'h0200; mem[2] = 16'h0300; mem[32] = 16'h0a0a;
      do_reset();
      cyc("R4 jump issue", 1, 32'hFFFF_0020, 0, 0, 1, 32'h0100_0000, 16'h0000, 0, 0);
      cyc("R4 delay slot", 0, 0, 0, 0, 1, 32'h0200_0000, 16'h0001, 0, 0);
      cyc("R4 R6 target", 0, 0, 0, 0, 1, 32'h0a0a_0000, 16'h0020, 0, 0);
   endtask

   task automatic t_jump_long_slot();
      clear_rom();
      mem[0] = 16'h0100; mem[1] = 16'h8111; mem[2] = 16'h2222; mem[16] = 16'h0777;
      do_reset();
      cyc("R5 jump issue", 1, 32'h0001_0010, 0, 0, 1, 32'h0100_0000, 16'h0000, 0, 0);
      cyc("R5 slot first half", 0, 0, 0, 0, 0, 32'h0, 16'h0001, 0, 1);
      cyc("R5 slot second half", 0, 0, 0, 0, 1, 32'h8111_2222, 16'h0002, 0, 0);
      cyc("R5 target", 0, 0, 0, 0, 1, 32'h0777_0000, 16'h0010, 0, 0);
   endtask

   task automatic t_jump_in_slot();
      clear_rom();
      mem[0] = 16'h0100; mem[1] = 16'h0101; mem[8] = 16'h0888; mem[9] = 16'h0999;
      mem[48] = 16'h0bad;
      do_reset();
      cyc("R7 first jump", 1, 32'h8, 0, 0, 1, 32'h0100_0000, 16'h0000, 0, 0);
      cyc("R7 jump in slot", 1, 32'h30, 0, 0, 1, 32'h0101_0000, 16'h0001, 0, 0);
      cyc("R7 first target", 0, 0, 0, 0, 1, 32'h0888_0000, 16'h0008, 0, 0);
      cyc("R7 continues sequential", 0, 0, 0, 0, 1, 32'h0999_0000, 16'h0009, 0, 0);
   endtask

   task automatic t_halt();
      clear_rom();
      mem[0] = 16'h0001; mem[1] = 16'h0002; mem[2] = 16'h0003;
      do_reset();
      cyc("R9 other interrupt", 0, 0, 1, 3'd2, 1, 32'h0001_0000, 16'h0000, 0, 0);
      cyc("R8 finish interrupt", 0, 0, 1, 3'd1, 1, 32'h0002_0000, 16'h0001, 0, 0);
      cyc("R8 halted", 1, 32'h0, 0, 0, 0, 32'h0, 16'hFFFF, 1, 0);
      cyc("R8 halt holds", 0, 0, 0, 0, 0, 32'h0, 16'hFFFF, 1, 0);
      cyc("R8 still halted", 0, 0, 0, 0, 0, 32'h0, 16'hFFFF, 1, 0);
   endtask

   task automatic t_misaligned();
      clear_rom();
      mem[0] = 16'h0011; mem[1] = 16'h8333; mem[2] = 16'h4444; mem[3] = 16'h0066;
      do_reset();
      cyc("R10 before", 0, 0, 0, 0, 1, 32'h0011_0000, 16'h0000, 0, 0);
      cyc("R10 odd long start", 0, 0, 0, 0, 0, 32'h0, 16'h0001, 0, 1);
      cyc("R10 odd long issue", 0, 0, 0, 0, 1, 32'h8333_4444, 16'h0002, 0, 0);
      cyc("R10 after", 0, 0, 0, 0, 1, 32'h0066_0000, 16'h0003, 0, 0);
   endtask

   initial begin
      t_sequential();
      t_jump_short_slot();
      t_jump_long_slot();
      t_jump_in_slot();
      t_halt();
      t_misaligned();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got no end, expected end of tests");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule